// File: doc/BRIEF.md
# DRAM subarray charge-sharing model

This block is a cycle-level functional model of a single DRAM subarray and its row of sense amplifiers. It accepts activate, precharge, read and write commands. An activate carries a set of rows to open. The model keeps one bit of bitline state. In that state the bitlines either rest at the precharged half level or hold full-rail values that the sense amplifiers have latched. The result of each activation depends on that state.

When the bitlines are precharged, opening one row senses it, latches it and restores it. Opening three rows at once resolves every column to the majority of the three cells and writes that result back into all three rows. When the bitlines are already latched, any newly opened row is overwritten with the latched values. Row copy, multi-copy and majority-based AND or OR are therefore ordinary command sequences. For example, a majority of A, B and an all-zero row gives A AND B.

Software reaches the latch one word at a time through a column address. The controller state machine has two states:
- `ST_PRECHARGED`, entered at reset and by precharge.
- `ST_LATCHED`, entered from `ST_PRECHARGED` by a legal activate.

Transitions:
- Activate in `ST_LATCHED` stays in `ST_LATCHED` and copies the latch into the new rows.
- Read and write in `ST_LATCHED` stay there.
- Precharge from either state returns to `ST_PRECHARGED`.
- Illegal commands leave the state unchanged.

Top module: `dram_subarray_model`

## Requirements
- R1: Reset clears every cell to 0, closes all rows, puts the model in the precharged state and holds `rvalid` and `err` low.
- R2: Activate with exactly one row selected while precharged loads that row into the latch, leaves the row's contents unchanged and enters the latched state.
- R3: Activate with exactly three rows selected while precharged sets every latch bit to the majority of the three cells in that column and overwrites all three rows with that result.
- R4: Activate with a non-empty row set while latched overwrites every selected row with the latch contents and adds the selected rows to the open set. Repeated activates make further copies.
- R5: Read while latched returns latch bits `[col*WORD_W +: WORD_W]` on `rdata` with `rvalid` high in the cycle after the command.
- R6: Write while latched replaces latch word `col` with `wdata` and writes the same word into every currently open row.
- R7: Precharge closes all rows and enters the precharged state without changing any row, and it never raises `err`.
- R8: Read or write while precharged raises `err` for one cycle after the command, keeps `rvalid` low and changes no row.
- R9: Activate with an empty row set, or while precharged with a row count other than 1 or 3, raises `err` for one cycle and changes neither state nor data.
- R10: Command code 0 (no operation) changes nothing and raises neither `rvalid` nor `err`. The command codes are: 1 activate, 2 precharge, 3 read, 4 write. Codes 5 to 7 behave like code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code (0 nop, 1 activate, 2 precharge, 3 read, 4 write) |
| row_sel | input | N_ROWS | Row set for activate, one bit per row |
| col | input | log2(ROW_W/WORD_W) | Word index within the row for read and write |
| wdata | input | WORD_W | Write data word |
| rdata | output | WORD_W | Read data word, valid with `rvalid` |
| rvalid | output | 1 | One-cycle pulse one cycle after a legal read |
| err | output | 1 | One-cycle pulse one cycle after an illegal command |

## Verification
A wrong bitline-state bit is the most damaging internal fault. It turns the next activation into a copy where a sense was due, or the other way round. At the ports this appears on the first read after that activation, one cycle after the read is issued. It can also appear much later, as corrupted data in a row that was meant only to be sensed. A read or write that slips past a stale precharged state shows up immediately as a missing or spurious `err` pulse in the cycle after the command. The bench therefore reopens each row individually after majority and copy sequences to expose overwrites that had no immediate symptom.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } cmd_e;

    typedef enum logic {
        ST_PRECHARGED = 1'b0,
        ST_LATCHED    = 1'b1
    } bl_state_e;
endpackage

// File: rtl/dsa_rowpick.sv
// Finds the first three selected rows of a mask and counts the selected rows.
module dsa_rowpick #(
    parameter int N_ROWS = 8,
    localparam int IDXW = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
    localparam int CNTW = $clog2(N_ROWS + 1)
) (
    input  logic [N_ROWS-1:0] mask,
    output logic [IDXW-1:0]   idx_a,
    output logic [IDXW-1:0]   idx_b,
    output logic [IDXW-1:0]   idx_c,
    output logic [CNTW-1:0]   cnt
);
    always_comb begin
        idx_a = '0;
        idx_b = '0;
        idx_c = '0;
        cnt   = '0;
        for (int i = 0; i < N_ROWS; i++) begin
            if (mask[i]) begin
                if (cnt == CNTW'(0))      idx_a = IDXW'(i);
                else if (cnt == CNTW'(1)) idx_b = IDXW'(i);
                else if (cnt == CNTW'(2)) idx_c = IDXW'(i);
                cnt = cnt + CNTW'(1);
            end
        end
    end
endmodule

// File: rtl/dsa_maj3.sv
// Column-wise majority of three full rows: the digital result of charge sharing.
module dsa_maj3 #(
    parameter int ROW_W = 65536
) (
    input  logic [ROW_W-1:0] a,
    input  logic [ROW_W-1:0] b,
    input  logic [ROW_W-1:0] c,
    output logic [ROW_W-1:0] y
);
    assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/dram_subarray_model.sv
module dram_subarray_model
    import dsa_pkg::*;
#(
    parameter int ROW_W  = 65536,
    parameter int WORD_W = 16,
    parameter int N_ROWS = 8,
    localparam int N_WORDS = ROW_W / WORD_W,
    localparam int COLW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int IDXW = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
    localparam int CNTW = $clog2(N_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [N_ROWS-1:0] row_sel,
    input  logic [COLW-1:0]   col,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    output logic              err
);
    // Cell array and sense-amplifier state
    logic [ROW_W-1:0]  mem [N_ROWS];
    bl_state_e         st, st_d;
    logic [N_ROWS-1:0] open_q, open_d;
    logic [ROW_W-1:0]  latch_q, latch_d;

    // Resolution datapath
    logic [N_ROWS-1:0] wb_mask;
    logic [ROW_W-1:0]  wb_val;
    logic              illegal, rd_hit;
    cmd_e              cmd_v;

    logic [IDXW-1:0]   idx_a, idx_b, idx_c;
    logic [CNTW-1:0]   sel_cnt;
    logic [ROW_W-1:0]  maj_row;

    assign cmd_v = cmd_e'(cmd);

    dsa_rowpick #(.N_ROWS(N_ROWS)) u_pick (
        .mask  (row_sel),
        .idx_a (idx_a),
        .idx_b (idx_b),
        .idx_c (idx_c),
        .cnt   (sel_cnt)
    );

    dsa_maj3 #(.ROW_W(ROW_W)) u_maj (
        .a (mem[idx_a]),
        .b (mem[idx_b]),
        .c (mem[idx_c]),
        .y (maj_row)
    );

    // Next-state resolution of each command
    always_comb begin
        st_d    = st;
        open_d  = open_q;
        latch_d = latch_q;
        wb_mask = '0;
        wb_val  = latch_q;
        illegal = 1'b0;
        rd_hit  = 1'b0;
        unique case (cmd_v)
            CMD_ACT: begin
                if (row_sel == '0) begin
                    illegal = 1'b1;
                end else if (st == ST_PRECHARGED) begin
                    if (sel_cnt == CNTW'(1)) begin
                        latch_d = mem[idx_a];
                        wb_val  = mem[idx_a];
                        wb_mask = row_sel;
                        open_d  = row_sel;
                        st_d    = ST_LATCHED;
                    end else if (sel_cnt == CNTW'(3)) begin
                        latch_d = maj_row;
                        wb_val  = maj_row;
                        wb_mask = row_sel;
                        open_d  = row_sel;
                        st_d    = ST_LATCHED;
                    end else begin
                        illegal = 1'b1;
                    end
                end else begin
                    wb_mask = row_sel;
                    wb_val  = latch_q;
                    open_d  = open_q | row_sel;
                end
            end
            CMD_PRE: begin
                st_d   = ST_PRECHARGED;
                open_d = '0;
            end
            CMD_RD: begin
                if (st == ST_PRECHARGED) illegal = 1'b1;
                else                     rd_hit  = 1'b1;
            end
            CMD_WR: begin
                if (st == ST_PRECHARGED) begin
                    illegal = 1'b1;
                end else begin
                    latch_d[col*WORD_W +: WORD_W] = wdata;
                    wb_val  = latch_d;
                    wb_mask = open_q;
                end
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_PRECHARGED;
            open_q  <= '0;
            latch_q <= '0;
        end else begin
            st      <= st_d;
            open_q  <= open_d;
            latch_q <= latch_d;
        end
    end

    // Cell array write-back (restore, copy, majority, write)
    always_ff @(posedge clk) begin
        for (int r = 0; r < N_ROWS; r++) begin
            if (!rst_n)          mem[r] <= '0;
            else if (wb_mask[r]) mem[r] <= wb_val;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            err    <= 1'b0;
        end else begin
            rvalid <= rd_hit;
            err    <= illegal;
            if (rd_hit) rdata <= latch_q[col*WORD_W +: WORD_W];
        end
    end

    // Checks
    function automatic logic [IDXW-1:0] first_open(input logic [N_ROWS-1:0] m);
        logic [IDXW-1:0] k;
        k = '0;
        for (int i = N_ROWS - 1; i >= 0; i--) if (m[i]) k = IDXW'(i);
        return k;
    endfunction

    p_act_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v == CMD_ACT && st == ST_PRECHARGED && row_sel != '0 &&
         (sel_cnt == CNTW'(1) || sel_cnt == CNTW'(3))) |=> (st == ST_LATCHED && open_q != '0));

    p_open_row_holds_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LATCHED) |-> (mem[first_open(open_q)] == latch_q));

    p_rvalid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(cmd_v == CMD_RD));

    p_pre_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v == CMD_PRE) |=> (st == ST_PRECHARGED && open_q == '0 && !err));

    p_idle_access_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRECHARGED && (cmd_v == CMD_RD || cmd_v == CMD_WR)) |=> (err && !rvalid));

    p_bad_act_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v == CMD_ACT && st == ST_PRECHARGED && sel_cnt != CNTW'(1) && sel_cnt != CNTW'(3))
        |=> (st == ST_PRECHARGED && err));

    p_nop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v == CMD_NOP) |=> (!err && !rvalid && $stable(st)));
endmodule

// File: tb/sim_dram_subarray_model.sv
`timescale 1ns/1ps
module sim_dram_subarray_model;
    localparam int ROW_W  = 16;
    localparam int WORD_W = 4;
    localparam int N_ROWS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic [3:0] row_sel = 4'h0;
    logic [1:0] col = 2'd0;
    logic [3:0] wdata = 4'h0;
    logic [3:0] rdata;
    logic       rvalid, err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dram_subarray_model #(.ROW_W(ROW_W), .WORD_W(WORD_W), .N_ROWS(N_ROWS)) u0 (
        .clk, .rst_n, .cmd, .row_sel, .col, .wdata, .rdata, .rvalid, .err
    );

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] cmd;
        logic [3:0] mask;
        logic [1:0] col;
        logic [3:0] wd;
        logic       ev;
        logic       ee;
        logic [3:0] ed;
    } vec_t;

    // cmd: 0 nop, 1 act, 2 pre, 3 rd, 4 wr
    localparam int NV = 48;
    localparam vec_t VEC [NV] = '{
        '{4'd8, 3'd3, 4'h0, 2'd0, 4'h0, 1'b0, 1'b1, 4'h0}, // R8 read while precharged
        '{4'd2, 3'd1, 4'h1, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R2 open row0
        '{4'd6, 3'd4, 4'h0, 2'd0, 4'hA, 1'b0, 1'b0, 4'h0}, // R6
        '{4'd6, 3'd4, 4'h0, 2'd1, 4'h5, 1'b0, 1'b0, 4'h0},
        '{4'd6, 3'd4, 4'h0, 2'd2, 4'hC, 1'b0, 1'b0, 4'h0},
        '{4'd6, 3'd4, 4'h0, 2'd3, 4'h3, 1'b0, 1'b0, 4'h0},
        '{4'd5, 3'd3, 4'h0, 2'd2, 4'h0, 1'b1, 1'b0, 4'hC}, // R5
        '{4'd5, 3'd3, 4'h0, 2'd0, 4'h0, 1'b1, 1'b0, 4'hA},
        '{4'd4, 3'd1, 4'h2, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R4 copy into row1
        '{4'd6, 3'd4, 4'h0, 2'd1, 4'h6, 1'b0, 1'b0, 4'h0}, // R6 write to both open rows
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R7
        '{4'd2, 3'd1, 4'h1, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd6, 3'd3, 4'h0, 2'd1, 4'h0, 1'b1, 1'b0, 4'h6}, // R6 row0 got the word
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd2, 3'd1, 4'h4, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R2 open row2
        '{4'd6, 3'd4, 4'h0, 2'd0, 4'hF, 1'b0, 1'b0, 4'h0},
        '{4'd6, 3'd4, 4'h0, 2'd2, 4'hF, 1'b0, 1'b0, 4'h0},
        '{4'd6, 3'd4, 4'h0, 2'd3, 4'hE, 1'b0, 1'b0, 4'h0},
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd2, 3'd1, 4'h2, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R2 open row1
        '{4'd6, 3'd4, 4'h0, 2'd3, 4'h5, 1'b0, 1'b0, 4'h0},
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd3, 3'd1, 4'h7, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R3 majority rows 0,1,2
        '{4'd3, 3'd3, 4'h0, 2'd3, 4'h0, 1'b1, 1'b0, 4'h7}, // R3 maj(3,5,E)=7
        '{4'd3, 3'd3, 4'h0, 2'd0, 4'h0, 1'b1, 1'b0, 4'hA},
        '{4'd4, 3'd1, 4'h8, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R4 copy into row3
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd4, 3'd1, 4'h8, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd4, 3'd3, 4'h0, 2'd3, 4'h0, 1'b1, 1'b0, 4'h7}, // R4 row3 holds copy
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd3, 3'd1, 4'h1, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd3, 3'd3, 4'h0, 2'd3, 4'h0, 1'b1, 1'b0, 4'h7}, // R3 row0 overwritten
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd3, 3'd1, 4'h4, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd3, 3'd3, 4'h0, 2'd1, 4'h0, 1'b1, 1'b0, 4'h6}, // R3 row2 overwritten
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd9, 3'd1, 4'h3, 2'd0, 4'h0, 1'b0, 1'b1, 4'h0}, // R9 two rows
        '{4'd9, 3'd3, 4'h0, 2'd0, 4'h0, 1'b0, 1'b1, 4'h0}, // R9 still precharged
        '{4'd9, 3'd1, 4'h0, 2'd0, 4'h0, 1'b0, 1'b1, 4'h0}, // R9 empty set
        '{4'd8, 3'd4, 4'h0, 2'd0, 4'h0, 1'b0, 1'b1, 4'h0}, // R8 write while precharged
        '{4'd10, 3'd0, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R10
        '{4'd8, 3'd1, 4'h2, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd8, 3'd3, 4'h0, 2'd0, 4'h0, 1'b1, 1'b0, 4'hA}, // R8 ignored write left A
        '{4'd9, 3'd1, 4'h0, 2'd0, 4'h0, 1'b0, 1'b1, 4'h0}, // R9 empty set while latched
        '{4'd10, 3'd7, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0}, // R10 unused code
        '{4'd9, 3'd3, 4'h0, 2'd3, 4'h0, 1'b1, 1'b0, 4'h7}, // R9 latch untouched
        '{4'd7, 3'd2, 4'h0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h0},
        '{4'd7, 3'd3, 4'h0, 2'd0, 4'h0, 1'b0, 1'b1, 4'h0}  // R7 now precharged
    };

    task automatic chk(input int req, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic [3:0] m, input logic [1:0] k, input logic [3:0] d);
        @(negedge clk);
        cmd = c; row_sel = m; col = k; wdata = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(1, "rvalid in reset", {3'b0, rvalid}, 4'h0); // R1
        chk(1, "err in reset", {3'b0, err}, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].cmd, VEC[i].mask, VEC[i].col, VEC[i].wd);
            chk(int'(VEC[i].req), $sformatf("vec%0d rvalid", i), {3'b0, rvalid}, {3'b0, VEC[i].ev});
            chk(int'(VEC[i].req), $sformatf("vec%0d err", i), {3'b0, err}, {3'b0, VEC[i].ee});
            if (VEC[i].ev) chk(int'(VEC[i].req), $sformatf("vec%0d rdata", i), rdata, VEC[i].ed);
        end

        // R1: reset mid-run clears cells and state
        issue(3'd1, 4'h2, 2'd0, 4'h0);
        @(negedge clk);
        rst_n = 1'b0;
        cmd = 3'd0;
        @(posedge clk);
        #1;
        chk(1, "rvalid after reset", {3'b0, rvalid}, 4'h0);
        chk(1, "err after reset", {3'b0, err}, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        issue(3'd3, 4'h0, 2'd0, 4'h0);
        chk(1, "precharged after reset", {3'b0, err}, 4'h1);
        issue(3'd1, 4'h2, 2'd0, 4'h0);
        issue(3'd3, 4'h0, 2'd3, 4'h0);
        chk(1, "row1 cleared", rdata, 4'h0);
        chk(1, "read valid", {3'b0, rvalid}, 4'h1);

        // R6/R4: write while several rows open updates each of them
        issue(3'd1, 4'h9, 2'd0, 4'h0);
        issue(3'd4, 4'h0, 2'd2, 4'h9);
        issue(3'd2, 4'h0, 2'd0, 4'h0);
        issue(3'd1, 4'h8, 2'd0, 4'h0);
        issue(3'd3, 4'h0, 2'd2, 4'h0);
        chk(6, "row3 written while open", rdata, 4'h9);
        issue(3'd2, 4'h0, 2'd0, 4'h0);
        issue(3'd1, 4'h1, 2'd0, 4'h0);
        issue(3'd3, 4'h0, 2'd2, 4'h0);
        chk(4, "row0 copied then written", rdata, 4'h9);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule